// File: doc/BRIEF.md
# Two-Bank Interrupt Event Controller

This block gathers up to 64 interrupt sources into two banks of 32 and drives one request line to a processor. Each bank keeps a latch of rising edges, a mask of enabled sources, an acknowledge port that clears latched edges bit by bit, and a view of the raw source lines. Software reaches all of these through a simple word-wide register bus inside a 64-byte window. Alongside the request line the block also reports the number of the highest pending source.

A source counts as pending while it is enabled and it either has a latched edge or has stayed high since a rising edge that it made while enabled. Turning on the mask bit of a source that is already high therefore raises nothing. A handler can acknowledge the latched edge, and the request stays up for as long as the line remains high.

Top module: `intc_top`

## Requirements
- R1: After reset all enable bits and all latched events are 0, `irq_o` and `pend_valid_o` are 0, and enable registers read back as 0.
- R2: Source n lives in bank n[5], at bit n[4:0]. Bank 0 (sources 0..31) has its base at window offset 0x20 and bank 1 (sources 32..63) has its base at 0x10. From a base, the event register is at +0x0, the enable at +0x4, the acknowledge at +0x8 and the level at +0xC. Address bits [1:0] are ignored, and bit k of a data word is bit k of the register.
- R3: Reading an enable register returns the last value written to it.
- R4: A rising edge of a source sets its event bit only if its enable bit is 1 in that cycle. A rising edge of a masked source leaves the event register unchanged.
- R5: Writing the acknowledge register clears every event bit whose position is 1 in the written word and leaves the event bits at 0 positions unchanged. The acknowledge register reads as 0.
- R6: When a rising edge and an acknowledge of the same event bit fall in the same cycle, the bit ends up set.
- R7: The level register returns each source's raw state as sampled at the last clock edge, whatever the enable and event bits hold.
- R8: Setting an enable bit while its source is already high sets no event and raises no request. Clearing and then setting it again while the source stays high also raises no request.
- R9: `irq_o` is 1 exactly when some enabled source has a latched event, or has stayed high since a rising edge it made while enabled. It follows a source change or a register write by one clock.
- R10: `pend_valid_o` equals `irq_o`, and `pend_id_o` gives the highest-numbered pending source.
- R11: Offsets 0x00..0x0F and 0x30..0x3F read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Raw interrupt source lines |
| bus_addr | input | 6 | Byte offset inside the register window |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |
| pend_valid_o | output | 1 | Some source is pending |
| pend_id_o | output | 6 | Highest pending source number |

## Verification
The stimulus covers a rising edge on an enabled source, a rising edge on a masked source, a falling edge after the event has latched, and a source that is already high when it gets enabled. Between them these cases separate the latched event from the armed level and from the raw level view. Further runs set sources in both banks at once, which checks the bank address swap and the highest-number pick. They also acknowledge while the line is still high, to show that the request lasts as long as the level. Directed cases place an edge and an acknowledge in the same cycle, run partial acknowledges, access unused offsets and apply reset in the middle of a run.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int SRC_PER_BANK = 32;
    localparam int NUM_BANKS    = 2;
    localparam int NUM_SRC      = SRC_PER_BANK * NUM_BANKS;
    localparam int ID_W         = $clog2(NUM_SRC);
    localparam int ADDR_W       = 6;
    localparam int DATA_W       = SRC_PER_BANK;
    localparam int BANK0_BASE   = 32;
    localparam int BANK_STRIDE  = 16;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     we;
        reg_sel_e sel;
    } bank_req_t;

    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        return ADDR_W'(BANK0_BASE - BANK_STRIDE * b);
    endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
(
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr,
    output bank_req_t [NUM_BANKS-1:0]       req
);
    localparam int OFS_W = 4;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = bank_base(b);
        always_comb begin
            req[b].hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
            req[b].we  = wr;
            req[b].sel = reg_sel_e'(addr[OFS_W-1:2]);
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int W = SRC_PER_BANK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  src,
    input  bank_req_t     req,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  ev,
    output logic [W-1:0]  en,
    output logic [W-1:0]  lvl,
    output logic [W-1:0]  pend
);
    logic [W-1:0] ev_q, en_q, lvl_q, arm_q;
    logic [W-1:0] rise, cap, ack_m, en_n, ev_n, arm_n;
    logic         wr_en, wr_ack;

    always_comb begin
        wr_en  = req.hit && req.we && (req.sel == REG_ENABLE);
        wr_ack = req.hit && req.we && (req.sel == REG_ACK);
        rise   = src & ~lvl_q;
        cap    = rise & en_q;
        ack_m  = wr_ack ? wdata : '0;
        en_n   = wr_en ? wdata : en_q;
        ev_n   = (ev_q & ~ack_m) | cap;
        arm_n  = src & en_n & (arm_q | cap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q  <= '0;
            en_q  <= '0;
            lvl_q <= '0;
            arm_q <= '0;
        end else begin
            ev_q  <= ev_n;
            en_q  <= en_n;
            lvl_q <= src;
            arm_q <= arm_n;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.hit) begin
            unique case (req.sel)
                REG_EVENT:  rdata = ev_q;
                REG_ENABLE: rdata = en_q;
                REG_ACK:    rdata = '0;
                REG_LEVEL:  rdata = lvl_q;
            endcase
        end
    end

    assign ev   = ev_q;
    assign en   = en_q;
    assign lvl  = lvl_q;
    assign pend = (ev_q | arm_q) & en_q;
endmodule

// File: rtl/intc_highest.sv
module intc_highest #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    pend,
    output logic            valid,
    output logic [ID_W-1:0] id
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                valid = 1'b1;
                id    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              pend_valid_o,
    output logic [ID_W-1:0]   pend_id_o
);
    bank_req_t [NUM_BANKS-1:0] req;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [NUM_SRC-1:0] ev_all, en_all, lvl_all, pend_all;

    intc_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .req  (req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank #(.W(SRC_PER_BANK)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .src   (src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .req   (req[b]),
            .wdata (bus_wdata),
            .rdata (bank_rd[b]),
            .ev    (ev_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .en    (en_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .lvl   (lvl_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pend  (pend_all[b*SRC_PER_BANK +: SRC_PER_BANK])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= bank_rd[b];
    end

    assign irq_o = |pend_all;

    intc_highest #(.N(NUM_SRC), .ID_W(ID_W)) u_hi (
        .pend  (pend_all),
        .valid (pend_valid_o),
        .id    (pend_id_o)
    );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic               pend_valid_o,
    input logic [ID_W-1:0]    pend_id_o,
    input logic [NUM_SRC-1:0] ev_all,
    input logic [NUM_SRC-1:0] en_all,
    input logic [NUM_SRC-1:0] lvl_all
);
    logic [NUM_SRC-1:0] cand;
    assign cand = (ev_all | lvl_all) & en_all;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && en_all == '0 && ev_all == '0)); // R1

    AST_IRQ_EQ_VALID: assert property (@(posedge clk) disable iff (rst)
        irq_o == pend_valid_o); // R10

    AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (ev_all & ~$past(ev_all) & ~$past(en_all)) == '0); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && $past(bus_addr[5:2]) == 4'b1010) |->
        ((ev_all[31:0] & $past(bus_wdata)
          & ~($past(src_i[31:0]) & ~$past(lvl_all[31:0]))) == '0)); // R5

    AST_ID_PENDING: assert property (@(posedge clk) disable iff (rst)
        pend_valid_o |-> cand[pend_id_o]); // R10

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[5:4] == 2'b00 || bus_addr[5:4] == 2'b11) |-> bus_rdata == '0); // R11
endmodule

bind intc_top intc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_i        (src_i),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_o        (irq_o),
    .pend_valid_o (pend_valid_o),
    .pend_id_o    (pend_id_o),
    .ev_all       (ev_all),
    .en_all       (en_all),
    .lvl_all      (lvl_all)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, pend_valid_o;
    logic [5:0]  pend_id_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    intc_top dut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .pend_valid_o(pend_valid_o), .pend_id_o(pend_id_o)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [63:0] src;
        logic        irq;
        logic [5:0]  id;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'h24, 32'h0,   64'h0,           1'b0, 6'd0 },  // R1 enable 0
        '{1'b1, 6'h24, 32'h11,  64'h0,           1'b0, 6'd0 },
        '{1'b0, 6'h24, 32'h11,  64'h0,           1'b0, 6'd0 },  // R3 readback
        '{1'b0, 6'h20, 32'h10,  64'h10,          1'b1, 6'd4 },  // R4 edge latched
        '{1'b0, 6'h2C, 32'h10,  64'h10,          1'b1, 6'd4 },  // R7 level
        '{1'b0, 6'h20, 32'h10,  64'h0,           1'b1, 6'd4 },  // R9 event held
        '{1'b1, 6'h28, 32'h10,  64'h0,           1'b0, 6'd0 },  // R5 ack
        '{1'b0, 6'h20, 32'h0,   64'h0,           1'b0, 6'd0 },  // R5 cleared
        '{1'b0, 6'h20, 32'h0,   64'h100,         1'b0, 6'd0 },  // R4 masked edge
        '{1'b0, 6'h2C, 32'h100, 64'h100,         1'b0, 6'd0 },  // R7 level masked
        '{1'b1, 6'h24, 32'h111, 64'h100,         1'b0, 6'd0 },  // R8 enable high src
        '{1'b0, 6'h20, 32'h0,   64'h100,         1'b0, 6'd0 },  // R8 no event
        '{1'b1, 6'h14, 32'h1,   64'h100,         1'b0, 6'd0 },  // R2 bank1 enable
        '{1'b0, 6'h10, 32'h1,   64'h1_0000_0100, 1'b1, 6'd32},  // R2 bank1 event
        '{1'b0, 6'h20, 32'h1,   64'h1_0000_0101, 1'b1, 6'd32},  // R10 highest
        '{1'b1, 6'h18, 32'h1,   64'h1_0000_0101, 1'b1, 6'd32},  // R9 level holds
        '{1'b0, 6'h10, 32'h0,   64'h101,         1'b1, 6'd0 },  // R10 next lower
        '{1'b0, 6'h00, 32'h0,   64'h101,         1'b1, 6'd0 },  // R11 unused read
        '{1'b1, 6'h04, 32'hFFFF_FFFF, 64'h101,   1'b1, 6'd0 },  // R11 unused write
        '{1'b0, 6'h24, 32'h111, 64'h101,         1'b1, 6'd0 },  // R11 no effect
        '{1'b1, 6'h28, 32'h1,   64'h101,         1'b1, 6'd0 },  // R9 armed stays
        '{1'b1, 6'h24, 32'h0,   64'h101,         1'b0, 6'd0 },  // R9 disable drops
        '{1'b1, 6'h24, 32'h111, 64'h101,         1'b0, 6'd0 }   // R8 re-enable quiet
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [5:0] a, input logic [31:0] d,
                         input logic [63:0] s);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_i = s;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
        chk(pend_valid_o == 1'b0, "R1 valid", pend_valid_o, 0);
        bus_addr = 6'h14; #0.5;
        chk(bus_rdata == 0, "R1 enable bank1", bus_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].src);
            bus_addr = VECS[i].addr; #0.5;
            if (!VECS[i].wr)
                chk(bus_rdata == VECS[i].data, $sformatf("R2 row%0d rdata", i),
                    bus_rdata, VECS[i].data);
            chk(irq_o == VECS[i].irq, $sformatf("R9 row%0d irq", i), irq_o, VECS[i].irq);
            if (VECS[i].irq)
                chk(pend_id_o == VECS[i].id, $sformatf("R10 row%0d id", i),
                    pend_id_o, VECS[i].id);
        end

        // R6: edge and acknowledge on bit 4 in the same cycle
        drive(1'b0, 6'h20, 32'h0, 64'h100);
        drive(1'b1, 6'h28, 32'h10, 64'h110);
        bus_addr = 6'h20; #0.5;
        chk(bus_rdata == 32'h10, "R6 set wins", bus_rdata, 32'h10);
        chk(irq_o && pend_id_o == 6'd4, "R6 irq id", {irq_o, pend_id_o}, {1'b1, 6'd4});

        // R5: partial acknowledge keeps other bits
        drive(1'b0, 6'h20, 32'h0, 64'h111);
        bus_addr = 6'h20; #0.5;
        chk(bus_rdata == 32'h11, "R4 two events", bus_rdata, 32'h11);
        drive(1'b1, 6'h28, 32'h10, 64'h111);
        bus_addr = 6'h20; #0.5;
        chk(bus_rdata == 32'h01, "R5 partial ack", bus_rdata, 32'h01);
        bus_addr = 6'h28; #0.5;
        chk(bus_rdata == 32'h0, "R5 ack reads 0", bus_rdata, 0);
        bus_addr = 6'h3C; #0.5;
        chk(bus_rdata == 32'h0, "R11 high unused", bus_rdata, 0);

        // R1: reset in the middle of a run
        @(negedge clk);
        do_reset();
        bus_addr = 6'h24; #0.5;
        chk(bus_rdata == 32'h0, "R1 enable after reset", bus_rdata, 0);
        chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule